// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a 9-bit first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock when the write enables allow it and leave through a registered read port on the read clock. The read port drives a tri-state data bus. The block reports four conditions. Empty and almost-empty are produced in the read-clock domain. Full and almost-full are produced in the write-clock domain. The almost thresholds are offsets held in a small loader inside the block. The storage depth is a power-of-two parameter. Each pointer carries one extra bit so that a full buffer can be told apart from an empty one, and each pointer crosses into the other domain as a Gray code through two flip-flops.

The shared second write-enable pin has two possible roles. The clock edges that occur while reset is low sample its level. A high level selects dual-enable mode. A low level selects load mode, in which the pin becomes a strobe for loading the offsets.

The offset loader is a four-state machine: `OFS_E_LO` → `OFS_E_HI` → `OFS_F_LO` → `OFS_F_HI` → back to `OFS_E_LO`. Each load cycle writes one byte into the register that the current state selects, then takes the transition to the next state. Any other cycle keeps the state, so a load session may stop part-way and a later session resumes where it stopped. The configuration register has two values: `MODE_DUAL_EN` and `MODE_PROG`.

Top module: `fifo_dc9`

## Requirements
- R1: A word is written on a rising `wclk` edge when `wen1_n` is 0 and `wen2_ld` is 1. If `wen2_ld` is 0, no word is stored in either mode.
- R2: A read happens on a rising `rclk` edge when `ren1_n` and `ren2_n` are both 0. Each read loads the next word, in write order, into the output register.
- R3: While `full` is 1, writes are refused. A word offered to a full buffer is never stored.
- R4: While `empty` is 1, reads are refused. The output register keeps the last word that was validly read.
- R5: While `rst_n` is low, the outputs take the following values: `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, output register 0. Both offsets take the value 7.
- R6: The clock edges that occur while `rst_n` is low sample `wen2_ld`. A 1 selects dual-enable mode, in which `wen2_ld`=0 has no effect on the offsets. A 0 selects load mode. In load mode, `wen1_n`=0 with `wen2_ld`=0 is a load cycle, which stores nothing in the FIFO. Also in load mode, reads are suppressed while `wen2_ld` is 0.
- R7: Load cycles take `din[7:0]` into the empty-offset low byte, the empty-offset high byte, the full-offset low byte and the full-offset high byte, in that order, and then wrap. A later session continues from the next register in the sequence.
- R8: `almost_empty` is 1 when the stored word count is at or below the empty offset. It is updated only on `rclk`.
- R9: `almost_full` is 1 when the free space is at or below the full offset. It is updated only on `wclk`.
- R10: `full` is 1 when DEPTH words are held. `empty` is 1 when no word is held.
- R11: When `oe_n` is 0, `dout` shows the output register. When `oe_n` is 1, `dout` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 9 | Write data; bits 7:0 also carry offset bytes |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write enable (active high) or load strobe (active low) |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Tri-state read data |
| empty | output | 1 | No words held |
| almost_empty | output | 1 | Word count at or below empty offset |
| almost_full | output | 1 | Free space at or below full offset |
| full | output | 1 | DEPTH words held |

## Verification
The bench fills the buffer to exactly DEPTH words and then offers more. A design with a wrong full compare would store the extra word, and that word would then appear after the 64 expected reads. Reads are attempted on an empty buffer. A design without underflow blocking would corrupt the output register instead of keeping the last word. The bench checks the almost flags one word either side of each threshold, first with the default offsets and then with loaded offsets. An off-by-one compare would flip one of those two checks. The bench also loads only two offset bytes in one session and the rest in a later session. It exercises `wen2_ld`=0 in dual-enable mode as well. A loader that restarted its sequence, or that accepted loads in the wrong mode, would leave a threshold somewhere other than where the bench expects it.

// File: rtl/fifo_dc9_pkg.sv
package fifo_dc9_pkg;

    typedef enum logic [1:0] {
        OFS_E_LO = 2'd0,
        OFS_E_HI = 2'd1,
        OFS_F_LO = 2'd2,
        OFS_F_HI = 2'd3
    } ofs_sel_e;

    typedef enum logic {
        MODE_PROG    = 1'b0,
        MODE_DUAL_EN = 1'b1
    } wen_mode_e;

endpackage

// File: rtl/fifo_dc9_sync.sv
module fifo_dc9_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stage2 >> i);
        end
    end
endmodule

// File: rtl/fifo_dc9_ofs.sv
module fifo_dc9_ofs
    import fifo_dc9_pkg::*;
#(
    parameter int BW      = 8,
    parameter int DEF_OFS = 7,
    localparam int OW     = 2 * BW
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic [BW-1:0] ld_byte,
    output wen_mode_e     mode,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    ofs_sel_e sel;
    ofs_sel_e sel_nxt;
    logic     load_cyc;

    // configuration sampled on clock edges while reset is held low
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            mode <= wen2_ld ? MODE_DUAL_EN : MODE_PROG;
        end
    end

    assign load_cyc = (mode == MODE_PROG) && !wen1_n && !wen2_ld;

    // state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= OFS_E_LO;
        end else begin
            sel <= sel_nxt;
        end
    end

    // transitions
    always_comb begin
        sel_nxt = sel;
        if (load_cyc) begin
            unique case (sel)
                OFS_E_LO: sel_nxt = OFS_E_HI;
                OFS_E_HI: sel_nxt = OFS_F_LO;
                OFS_F_LO: sel_nxt = OFS_F_HI;
                OFS_F_HI: sel_nxt = OFS_E_LO;
            endcase
        end
    end

    // outputs: offset registers
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            empty_ofs <= OW'(DEF_OFS);
            full_ofs  <= OW'(DEF_OFS);
        end else if (load_cyc) begin
            unique case (sel)
                OFS_E_LO: empty_ofs[BW-1:0]  <= ld_byte;
                OFS_E_HI: empty_ofs[OW-1:BW] <= ld_byte;
                OFS_F_LO: full_ofs[BW-1:0]   <= ld_byte;
                OFS_F_HI: full_ofs[OW-1:BW]  <= ld_byte;
            endcase
        end
    end

    AST_SEL_ONLY_ON_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
        !load_cyc |=> $stable(sel)); // R7
endmodule

// File: rtl/fifo_dc9_wctl.sv
module fifo_dc9_wctl #(
    parameter int AW = 6,
    parameter int OW = 16
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   rbin_s,
    input  logic [OW-1:0] full_ofs,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_en,
    output logic          full,
    output logic          almost_full
);
    localparam logic [AW:0] DEPTH_W = {1'b1, {AW{1'b0}}};

    logic [AW:0] wbin_nxt;
    logic [AW:0] used_nxt;
    logic [AW:0] free_nxt;

    always_comb begin
        wr_en    = wr_req && !full;
        wbin_nxt = wbin + {{AW{1'b0}}, wr_en};
        used_nxt = wbin_nxt - rbin_s;
        free_nxt = DEPTH_W - used_nxt;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            full        <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wbin        <= wbin_nxt;
            wgray       <= wbin_nxt ^ (wbin_nxt >> 1);
            full        <= (used_nxt == DEPTH_W);
            almost_full <= (OW'(free_nxt) <= full_ofs);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        (wbin - rbin_s) <= DEPTH_W); // R3
    AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!rst_n)
        full |-> almost_full); // R9
endmodule

// File: rtl/fifo_dc9_rctl.sv
module fifo_dc9_rctl #(
    parameter int AW = 6,
    parameter int DW = 9,
    parameter int OW = 16
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW:0]   wbin_s,
    input  logic [OW-1:0] empty_ofs,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          empty,
    output logic          almost_empty
);
    logic [AW:0] rbin;
    logic [AW:0] rbin_nxt;
    logic [AW:0] used_nxt;
    logic        rd_en;

    always_comb begin
        rd_en    = rd_req && !empty;
        rbin_nxt = rbin + {{AW{1'b0}}, rd_en};
        used_nxt = wbin_s - rbin_nxt;
        raddr    = rbin[AW-1:0];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin         <= '0;
            rgray        <= '0;
            q            <= '0;
            empty        <= 1'b1;
            almost_empty <= 1'b1;
        end else begin
            rbin         <= rbin_nxt;
            rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
            empty        <= (used_nxt == '0);
            almost_empty <= (OW'(used_nxt) <= empty_ofs);
            if (rd_en) begin
                q <= rdata;
            end
        end
    end

    AST_HOLD_ON_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |=> $stable(q)); // R4
    AST_EMPTY_IMPLIES_AE: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |-> almost_empty); // R8
endmodule

// File: rtl/fifo_dc9.sv
module fifo_dc9
    import fifo_dc9_pkg::*;
#(
    parameter int DW      = 9,
    parameter int AW      = 6,
    parameter int BW      = 8,
    parameter int DEF_OFS = 7
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          wen1_n,
    input  logic          wen2_ld,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          full
);
    localparam int DEPTH = 1 << AW;
    localparam int OW    = 2 * BW;

    wen_mode_e     mode;
    logic [OW-1:0] empty_ofs;
    logic [OW-1:0] full_ofs;
    logic [AW:0]   wbin, wgray, rgray, wbin_s, rbin_s;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;
    logic [DW-1:0] q;
    logic          wr_req, wr_en, rd_req;
    logic [DW-1:0] mem [DEPTH];

    assign wr_req = !wen1_n && wen2_ld;
    assign rd_req = !ren1_n && !ren2_n && !((mode == MODE_PROG) && !wen2_ld);

    fifo_dc9_ofs #(.BW(BW), .DEF_OFS(DEF_OFS)) u_ofs (
        .wclk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .ld_byte(din[BW-1:0]), .mode(mode),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    fifo_dc9_wctl #(.AW(AW), .OW(OW)) u_wctl (
        .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rbin_s(rbin_s),
        .full_ofs(full_ofs), .wbin(wbin), .wgray(wgray), .wr_en(wr_en),
        .full(full), .almost_full(almost_full)
    );

    fifo_dc9_rctl #(.AW(AW), .DW(DW), .OW(OW)) u_rctl (
        .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wbin_s(wbin_s),
        .empty_ofs(empty_ofs), .rdata(rdata), .raddr(raddr), .rgray(rgray),
        .q(q), .empty(empty), .almost_empty(almost_empty)
    );

    fifo_dc9_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    fifo_dc9_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    always_ff @(posedge wclk) begin
        if (wr_en) begin
            mem[wbin[AW-1:0]] <= din;
        end
    end

    assign rdata = mem[raddr];
    assign dout  = oe_n ? {DW{1'bz}} : q;
endmodule

// File: tb/tb_fifo_dc9.sv
module tb_fifo_dc9;
    logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [8:0] din = '0;
    logic       wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
    logic [8:0] dout;
    logic       empty, almost_empty, almost_full, full;
    int         n_chk = 0, n_fail = 0;

    localparam logic [17:0] VEC [12] = '{
        {9'h000, 9'h000}, {9'h1FF, 9'h1FF}, {9'h155, 9'h155}, {9'h0AA, 9'h0AA},
        {9'h001, 9'h001}, {9'h100, 9'h100}, {9'h0F0, 9'h0F0}, {9'h10F, 9'h10F},
        {9'h033, 9'h033}, {9'h1CC, 9'h1CC}, {9'h07E, 9'h07E}, {9'h181, 9'h181}
    };

    fifo_dc9 dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
        .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
        .dout(dout), .empty(empty), .almost_empty(almost_empty),
        .almost_full(almost_full), .full(full)
    );

    always #10 wclk = ~wclk;
    always #13 rclk = ~rclk;

    task automatic chk(input string req, input logic ok, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ld);
        rst_n = 1'b0; wen2_ld = ld; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) @(negedge rclk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wclk); din = d; wen2_ld = 1'b1; wen1_n = 1'b0;
        @(negedge wclk); wen1_n = 1'b1;
    endtask

    task automatic load(input logic [8:0] d);
        @(negedge wclk); din = d; wen2_ld = 1'b0; wen1_n = 1'b0;
        @(negedge wclk); wen1_n = 1'b1;
    endtask

    task automatic pop();
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad;
        // reset, dual-enable mode
        do_reset(1'b1);
        chk("R5 empty", empty === 1'b1, 16'(empty), 16'd1);
        chk("R5 almost_empty", almost_empty === 1'b1, 16'(almost_empty), 16'd1);
        chk("R5 full", full === 1'b0, 16'(full), 16'd0);
        chk("R5 almost_full", almost_full === 1'b0, 16'(almost_full), 16'd0);
        chk("R5 dout", dout === 9'h000, 16'(dout), 16'h0);

        // vector table: write, see empty clear, read back
        foreach (VEC[i]) begin
            push(VEC[i][17:9]);
            settle();
            chk("R10 empty clears", empty === 1'b0, 16'(empty), 16'd0);
            pop();
            chk("R2 read data", dout === VEC[i][8:0], 16'(dout), 16'(VEC[i][8:0]));
        end

        // R1: second enable low blocks writes; R6 no offset change in this mode
        @(negedge wclk); din = 9'h1AA; wen2_ld = 1'b0; wen1_n = 1'b0;
        repeat (3) @(negedge wclk);
        wen1_n = 1'b1; wen2_ld = 1'b1;
        settle();
        chk("R1 no write with wen2 low", empty === 1'b1, 16'(empty), 16'd1);

        // R4: read on empty keeps last word
        pop(); pop();
        chk("R4 hold last word", dout === 9'h181, 16'(dout), 16'h181);

        // fill with default threshold 7 (R9, R6)
        for (int i = 0; i < 56; i++) push(9'(i + 100));
        chk("R9 af at free 8", almost_full === 1'b0, 16'(almost_full), 16'd0);
        push(9'(156));
        chk("R9 af at free 7 (R6 offset untouched)", almost_full === 1'b1, 16'(almost_full), 16'd1);
        chk("R10 not full at 57", full === 1'b0, 16'(full), 16'd0);
        for (int i = 57; i < 64; i++) push(9'(i + 100));
        chk("R10 full at depth", full === 1'b1, 16'(full), 16'd1);
        push(9'h1FF); push(9'h1FE);
        settle();

        bad = 0;
        for (int i = 0; i < 64; i++) begin
            pop();
            if (dout !== 9'(i + 100)) bad++;
            if (i == 55) chk("R8 ae at count 8", almost_empty === 1'b0, 16'(almost_empty), 16'd0);
            if (i == 56) chk("R8 ae at count 7", almost_empty === 1'b1, 16'(almost_empty), 16'd1);
        end
        chk("R2 order over full depth", bad == 0, 16'(bad), 16'd0);
        chk("R3 extra word not stored", empty === 1'b1, 16'(empty), 16'd1);
        settle();
        chk("R10 full clears", full === 1'b0, 16'(full), 16'd0);

        // R11 tri-state
        oe_n = 1'b1; #1;
        chk("R11 high impedance", dout === 9'bz, 16'(dout), 16'h0);
        oe_n = 1'b0; #1;
        chk("R11 driven", dout === 9'(163), 16'(dout), 16'(163));

        // load mode
        do_reset(1'b0);
        chk("R5 dout after reset", dout === 9'h000, 16'(dout), 16'h0);
        load(9'd3); load(9'd0);
        settle();
        chk("R6 load cycles store nothing", empty === 1'b1, 16'(empty), 16'd1);
        wen2_ld = 1'b1;
        push(9'h011); push(9'h012); push(9'h013); push(9'h014);
        settle();
        chk("R8 ae at count 4 over offset 3", almost_empty === 1'b0, 16'(almost_empty), 16'd0);
        @(negedge rclk); wen2_ld = 1'b0;
        pop();
        chk("R6 read suppressed while strobe low", dout === 9'h000, 16'(dout), 16'h0);
        @(negedge rclk); wen2_ld = 1'b1;
        pop();
        chk("R2 first word", dout === 9'h011, 16'(dout), 16'h011);
        chk("R7 ae at count 3 with loaded offset", almost_empty === 1'b1, 16'(almost_empty), 16'd1);
        pop(); pop(); pop();
        settle();
        // second session continues with full offset bytes
        load(9'd10); load(9'd0);
        wen2_ld = 1'b1;
        settle();
        for (int i = 0; i < 53; i++) push(9'(i));
        chk("R9 af at free 11", almost_full === 1'b0, 16'(almost_full), 16'd0);
        push(9'd53);
        chk("R7 af at free 10 after resumed load", almost_full === 1'b1, 16'(almost_full), 16'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule